// File: doc/BRIEF.md
# Low-Frequency Periodic Signaling Burst Generator

This block generates low-frequency periodic signaling (LFPS) bursts for a USB 3.x style link entirely in soft logic. It does not use the line encoder. Instead it writes raw parallel words straight to an unencoded serializer. The square wave is made from whole words: a run of all-ones words forms the high level and a run of all-zeros words forms the low level. Each level lasts `half_len` parallel-clock cycles. The square-wave frequency is therefore f_clk / (2 × `half_len`). Software picks `half_len` so that this frequency lies between 10 MHz and 50 MHz.

A burst lasts `burst_len` cycles. A new burst starts every `repeat_len` cycles, counted from the start of the previous burst. Between bursts the data word is all zeros and transmit electrical idle is asserted. The block also drives the detect-receiver control and two power-down fields (transmit and receive), which always hold the same value. There are two modes:
- **Signaling mode.** During a burst, electrical idle and detect-receiver are asserted together and both power-down fields are `2'b00`.
- **Wake mode.** During a burst, electrical idle and detect-receiver are released and both power-down fields are `2'b01`.

The block has three states:
- **ST_IDLE:** no activity.
- **ST_BURST:** a burst is being sent.
- **ST_GAP:** waiting between bursts.

The transitions are:
- **start-accept:** ST_IDLE to ST_BURST, on `start` with a valid configuration.
- **burst-end:** ST_BURST to ST_GAP.
- **burst-end-stop:** ST_BURST to ST_IDLE, when a stop is pending.
- **repeat:** ST_GAP to ST_BURST.
- **gap-stop:** ST_GAP to ST_IDLE.

Top module: `lfps_burst_gen`

## Requirements
- R1: After reset the block is in ST_IDLE with these outputs: `busy`=0, `cfg_err`=0, `tx_data`=0, `tx_elec_idle`=1, `tx_detect_rx`=0, and both power-down fields `2'b00`.
- R2: Within a burst, `tx_data` is only ever all-ones or all-zeros. The first word of every burst is all-ones, and the level flips after every `half_len` cycles.
- R3: Each burst lasts exactly `burst_len` cycles. The next burst starts `repeat_len` cycles after the previous burst started. In the gap between bursts, `tx_data`=0 and `tx_elec_idle`=1.
- R4: In signaling mode (`wake_mode`=0 at start), during a burst `tx_elec_idle`=1, `tx_detect_rx`=1 and `tx_pd`=`rx_pd`=`2'b00`. In the gap both fields stay `2'b00`.
- R5: In wake mode (`wake_mode`=1 at start), during a burst `tx_elec_idle`=0, `tx_detect_rx`=0 and `tx_pd`=`rx_pd`=`2'b01`. In the gap both fields stay `2'b01`.
- R6: A `stop` pulse during a burst does not shorten it. The block returns to ST_IDLE in the cycle after the last burst word. A `stop` pulse during a gap returns the block to ST_IDLE at the next edge. `busy` is 0 exactly when the block is in ST_IDLE.
- R7: A `start` is rejected if `burst_len` >= `repeat_len`, `burst_len`=0 or `half_len`=0. A rejected start leaves the block idle and sets `cfg_err`. The next accepted start clears `cfg_err`.
- R8: The block captures `half_len`, `burst_len`, `repeat_len` and `wake_mode` when it accepts a start. Changes to these inputs while busy have no effect, and a `start` while busy is ignored.
- R9: A `start` sampled at a clock edge puts the first burst word on `tx_data` right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin repeating bursts |
| stop | input | 1 | Request to end after the current burst |
| wake_mode | input | 1 | 1 selects wake mode, 0 selects signaling mode |
| half_len | input | CNT_W | Cycles per half-period of the square wave |
| burst_len | input | CNT_W | Burst duration in cycles |
| repeat_len | input | CNT_W | Cycles from one burst start to the next |
| tx_data | output | DATA_W | Raw parallel word to the serializer |
| tx_elec_idle | output | 1 | Transmit electrical-idle control |
| tx_detect_rx | output | 1 | Detect-receiver control |
| tx_pd | output | 2 | Transmit power-down field |
| rx_pd | output | 2 | Receive power-down field |
| busy | output | 1 | High whenever the block is not in ST_IDLE |
| cfg_err | output | 1 | The last start was rejected for a bad configuration |

## Verification
The embedded properties assume that every accepted configuration has a non-zero half-period and a burst shorter than the repeat interval. Under that assumption the counters can never pass their limits, and the gap state always lasts at least one cycle. The rejection logic is what enforces this. The bench therefore sends bad configurations only through the rejection path, and uses a valid triple for every accepted start. Inputs change only on falling edges, and the bench scrambles the configuration inputs while a run is active. This means the properties on captured configuration see real input activity, not quiet inputs.

// File: rtl/lfps_pkg.sv
package lfps_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_GAP   = 2'd2
    } lfps_state_e;

    localparam logic [1:0] PD_SIGNAL = 2'b00;
    localparam logic [1:0] PD_WAKE   = 2'b01;
endpackage

// File: rtl/lfps_wave.sv
module lfps_wave #(
    parameter int DATA_W = 40,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    input  logic [CNT_W-1:0]  half_len,
    output logic [DATA_W-1:0] word
);
    logic [CNT_W-1:0] ph_cnt;
    logic             level;
    logic             ph_wrap;

    assign ph_wrap = (ph_cnt == half_len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_cnt <= '0;
            level  <= 1'b1;
        end else if (restart) begin
            ph_cnt <= '0;
            level  <= 1'b1;
        end else if (run) begin
            if (ph_wrap) begin
                ph_cnt <= '0;
                level  <= ~level;
            end else begin
                ph_cnt <= ph_cnt + 1'b1;
            end
        end
    end

    assign word = run ? {DATA_W{level}} : '0;

    AST_HALF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (ph_cnt < half_len)); // R2
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && !ph_wrap) |=> (level == $past(level))); // R2
endmodule

// File: rtl/lfps_timing.sv
module lfps_timing #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             in_burst,
    input  logic             active,
    input  logic [CNT_W-1:0] burst_len,
    input  logic [CNT_W-1:0] repeat_len,
    output logic             burst_last,
    output logic             rep_last
);
    logic [CNT_W-1:0] b_cnt;
    logic [CNT_W-1:0] r_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_cnt <= '0;
            r_cnt <= '0;
        end else if (restart) begin
            b_cnt <= '0;
            r_cnt <= '0;
        end else begin
            if (in_burst) b_cnt <= b_cnt + 1'b1;
            if (active)   r_cnt <= r_cnt + 1'b1;
        end
    end

    assign burst_last = (b_cnt == burst_len - 1'b1);
    assign rep_last   = (r_cnt == repeat_len - 1'b1);

    AST_BURST_WITHIN_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        in_burst |-> (b_cnt <= r_cnt)); // R3
    AST_REPEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (r_cnt < repeat_len)); // R3
endmodule

// File: rtl/lfps_burst_gen.sv
module lfps_burst_gen
    import lfps_pkg::*;
#(
    parameter int DATA_W = 40,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              wake_mode,
    input  logic [CNT_W-1:0]  half_len,
    input  logic [CNT_W-1:0]  burst_len,
    input  logic [CNT_W-1:0]  repeat_len,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_elec_idle,
    output logic              tx_detect_rx,
    output logic [1:0]        tx_pd,
    output logic [1:0]        rx_pd,
    output logic              busy,
    output logic              cfg_err
);
    lfps_state_e      state, nxt;
    logic [CNT_W-1:0] lat_half, lat_burst, lat_rep;
    logic             lat_wake;
    logic             stop_pend;
    logic             cfg_ok;
    logic             accept;
    logic             enter_burst;
    logic             burst_last, rep_last;
    logic             stop_any;
    logic [DATA_W-1:0] wave_word;
    logic [1:0]       pd_mode;

    assign cfg_ok   = (half_len != '0) && (burst_len != '0) && (burst_len < repeat_len);
    assign accept   = (state == ST_IDLE) && start && cfg_ok;
    assign stop_any = stop || stop_pend;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (accept) nxt = ST_BURST;
            ST_BURST: if (burst_last) nxt = stop_any ? ST_IDLE : ST_GAP;
            ST_GAP: begin
                if (stop_any)      nxt = ST_IDLE;
                else if (rep_last) nxt = ST_BURST;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign enter_burst = (nxt == ST_BURST) && (state != ST_BURST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_half  <= '0;
            lat_burst <= '0;
            lat_rep   <= '0;
            lat_wake  <= 1'b0;
            cfg_err   <= 1'b0;
            stop_pend <= 1'b0;
        end else begin
            if (state == ST_IDLE) begin
                stop_pend <= 1'b0;
                if (start) begin
                    cfg_err <= !cfg_ok;
                    if (cfg_ok) begin
                        lat_half  <= half_len;
                        lat_burst <= burst_len;
                        lat_rep   <= repeat_len;
                        lat_wake  <= wake_mode;
                    end
                end
            end else if (stop) begin
                stop_pend <= 1'b1;
            end
        end
    end

    lfps_wave #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (enter_burst),
        .run      (state == ST_BURST),
        .half_len (lat_half),
        .word     (wave_word)
    );

    lfps_timing #(.CNT_W(CNT_W)) i_timing (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (enter_burst),
        .in_burst   (state == ST_BURST),
        .active     (state != ST_IDLE),
        .burst_len  (lat_burst),
        .repeat_len (lat_rep),
        .burst_last (burst_last),
        .rep_last   (rep_last)
    );

    assign pd_mode = lat_wake ? PD_WAKE : PD_SIGNAL;

    always_comb begin
        tx_data      = '0;
        tx_elec_idle = 1'b1;
        tx_detect_rx = 1'b0;
        tx_pd        = PD_SIGNAL;
        busy         = 1'b1;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_BURST: begin
                tx_data      = wave_word;
                tx_elec_idle = !lat_wake;
                tx_detect_rx = !lat_wake;
                tx_pd        = pd_mode;
            end
            ST_GAP: tx_pd = pd_mode;
            default: busy = 1'b0;
        endcase
        rx_pd = tx_pd;
    end

    AST_REJECT_BAD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && !cfg_ok) |=> (!busy && cfg_err)); // R7
    AST_NO_TRUNCATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && !burst_last) |=> (state == ST_BURST)); // R6
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(lat_burst) && $stable(lat_rep) && $stable(lat_half))); // R8
    AST_GAP_ONLY_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_GAP) |-> ($past(state) == ST_BURST)); // R3
endmodule

// File: tb/test_lfps_burst_gen.sv
module test_lfps_burst_gen;
    localparam int DATA_W = 40;
    localparam int CNT_W  = 16;
    localparam logic [DATA_W-1:0] ONES = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, stop = 1'b0, wake_mode = 1'b0;
    logic [CNT_W-1:0] half_len = '0, burst_len = '0, repeat_len = '0;
    logic [DATA_W-1:0] tx_data;
    logic tx_elec_idle, tx_detect_rx, busy, cfg_err;
    logic [1:0] tx_pd, rx_pd;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    lfps_burst_gen #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_lfps_burst_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .wake_mode(wake_mode),
        .half_len(half_len), .burst_len(burst_len), .repeat_len(repeat_len),
        .tx_data(tx_data), .tx_elec_idle(tx_elec_idle), .tx_detect_rx(tx_detect_rx),
        .tx_pd(tx_pd), .rx_pd(rx_pd), .busy(busy), .cfg_err(cfg_err)
    );

    // stimulus: half, burst, repeat, wake, expected all-ones words in first burst
    localparam int NV = 4;
    localparam int VEC [NV][5] = '{
        '{2,  8, 12, 0, 4},
        '{1,  5,  7, 1, 3},
        '{3, 10, 13, 0, 6},
        '{4, 16, 20, 1, 8}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // expected outputs at cycle t after an accepted start
    task automatic check_cycle(input int t, input int hp, input int bl, input int ri, input int w);
        int pos;
        logic [DATA_W-1:0] ed;
        logic eei, edr;
        logic [1:0] epd;
        pos = t % ri;
        epd = w ? 2'b01 : 2'b00;
        if (pos < bl) begin
            ed  = (((pos / hp) % 2) == 0) ? ONES : '0;
            eei = (w == 0);
            edr = (w == 0);
        end else begin
            ed = '0; eei = 1'b1; edr = 1'b0;
        end
        chk(tx_data == ed, (pos < bl) ? "R2 burst word" : "R3 gap word", 64'(tx_data), 64'(ed));
        chk(tx_elec_idle == eei && tx_detect_rx == edr, w ? "R5 wake ctrl" : "R4 signal ctrl",
            {tx_elec_idle, tx_detect_rx}, {eei, edr});
        chk(tx_pd == epd && rx_pd == epd, w ? "R5 pd" : "R4 pd", {tx_pd, rx_pd}, {epd, epd});
        chk(busy == 1'b1, "R3 busy in run", 64'(busy), 64'd1);
    endtask

    task automatic do_start(input int hp, input int bl, input int ri, input int w);
        half_len = CNT_W'(hp); burst_len = CNT_W'(bl); repeat_len = CNT_W'(ri); wake_mode = w[0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R8: scramble configuration inputs once accepted
        half_len = 16'd7; burst_len = 16'd1; repeat_len = 16'd3; wake_mode = ~wake_mode;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int ones;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 0 && cfg_err == 0, "R1 flags", {busy, cfg_err}, 0);
        chk(tx_data == '0 && tx_elec_idle && !tx_detect_rx, "R1 line", {tx_elec_idle, tx_detect_rx}, 2'b10);
        chk(tx_pd == 2'b00 && rx_pd == 2'b00, "R1 pd", {tx_pd, rx_pd}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            do_start(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
            // R9: first word all-ones right after start edge
            chk(tx_data == ONES, "R9 first word", 64'(tx_data), 64'(ONES));
            ones = 0;
            for (int t = 0; t < 2 * VEC[v][2]; t++) begin
                check_cycle(t, VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
                if (t < VEC[v][1] && tx_data == ONES) ones++;
                start = (t == VEC[v][1]);            // R8: start in gap is ignored
                stop  = (t == 2 * VEC[v][2] - 1);    // R6: stop in gap
                @(negedge clk);
            end
            start = 1'b0; stop = 1'b0;
            chk(ones == VEC[v][4], "R2 high word count", 64'(ones), 64'(VEC[v][4]));
            chk(busy == 0 && tx_elec_idle && tx_data == '0, "R6 gap stop idle", {busy, tx_elec_idle}, 2'b01);
            @(negedge clk);
        end

        // R6: stop during burst does not truncate
        do_start(2, 8, 12, 0);
        for (int t = 0; t < 8; t++) begin
            check_cycle(t, 2, 8, 12, 0);
            stop = (t == 2);
            @(negedge clk);
        end
        stop = 1'b0;
        chk(busy == 0, "R6 stop at burst end", 64'(busy), 0);
        chk(tx_data == '0 && tx_elec_idle, "R6 idle line", 64'(tx_data), 0);
        @(negedge clk);

        // R7: rejected configurations
        do_start(2, 12, 12, 0);
        chk(busy == 0 && cfg_err == 1, "R7 burst==repeat", {busy, cfg_err}, 2'b01);
        chk(tx_data == '0, "R7 no burst", 64'(tx_data), 0);
        do_start(2, 0, 12, 0);
        chk(busy == 0 && cfg_err == 1, "R7 zero burst", {busy, cfg_err}, 2'b01);
        do_start(0, 4, 12, 0);
        chk(busy == 0 && cfg_err == 1, "R7 zero half", {busy, cfg_err}, 2'b01);
        do_start(1, 3, 5, 1);
        chk(busy == 1 && cfg_err == 0, "R7 valid clears err", {busy, cfg_err}, 2'b10);
        check_cycle(0, 1, 3, 5, 1);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 0, "R6 idle after stop", 64'(busy), 0);

        summary();
    end
endmodule